// File: doc/BRIEF.md
# CSR Access Unit with Counters

This block carries out the register-access forms of a 32-bit SYSTEM-class instruction against a small control-and-status register file. The file holds three free-running 64-bit counters and one general read/write scratch register. The counters track clock cycles, real-time ticks and retired instructions. Each counter appears as two read-only 32-bit halves at fixed addresses. The scratch register is the one location on which write, set and clear can take effect, so those operations can be seen at the ports.

Each cycle the surrounding pipeline presents an instruction word, a valid qualifier and the value of the source register. In the same cycle the block returns the CSR's previous value and a writeback enable for the destination register. It also raises one of three flags for an environment call, a breakpoint or an illegal access. The CSR update takes effect at the next clock edge. The counters advance on their own enables independently of any instruction.

Top module: `csr_access_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all three counters and the scratch register are cleared to zero at that edge.
- R2: The cycle counter increments on every clock edge out of reset. Its low half reads at address 0xC00 and its high half at 0xC80.
- R3: The time counter increments only on edges where `tick_en` is high. Its halves read at 0xC01 (low) and 0xC81 (high).
- R4: The retired-instruction counter increments only on edges where `retire` is high. Its halves read at 0xC02 (low) and 0xC82 (high).
- R5: A valid CSR operation returns the addressed CSR's value from before the operation on `rd_data` in the same cycle, with `rd_we` high when the rd field (bits 11:7) is nonzero. The opcode is in bits 6:0 and must be 7'b1110011, funct3 is in bits 14:12, the rs1 field in bits 19:15 and the CSR address in bits 31:20.
- R6: funct3 001 replaces the CSR with `rs1_val`. funct3 101 replaces it with the rs1 field zero-extended to 32 bits.
- R7: funct3 010 and 110 OR the operand into the CSR. funct3 011 and 111 clear the CSR bits that are set in the operand. The operand is `rs1_val` for 010 and 011, and the zero-extended rs1 field for 110 and 111.
- R8: A set or clear whose rs1 field is zero performs no write, whatever the value of `rs1_val`, and is therefore legal on the read-only counter addresses.
- R9: A write attempt to any counter address raises `illegal`, leaves `rd_we` low and leaves every counter unchanged. A write attempt is funct3 001 or 101, or a set or clear with a nonzero rs1 field.
- R10: Any CSR operation on an address other than the six counter halves and the scratch address (default 0x800) raises `illegal`.
- R11: Word 0x00000073 raises `env_call` and word 0x00100073 raises `env_break`. Neither has any CSR effect or raises `rd_we`. Any other funct3 000 or funct3 100 SYSTEM word raises `illegal`. At most one of the three flags is high.
- R12: An rd field of zero holds `rd_we` low while the CSR update still happens.
- R13: A word whose opcode is not SYSTEM, or any word with `instr_valid` low, raises no flag and changes no CSR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Qualifies `instr` this cycle |
| instr | input | 32 | Instruction word |
| rs1_val | input | 32 | Value of the source register |
| retire | input | 1 | One instruction retired this cycle |
| tick_en | input | 1 | Real-time tick |
| rd_data | output | 32 | Previous value of the addressed CSR |
| rd_we | output | 1 | Destination register write enable |
| env_call | output | 1 | Environment call recognised |
| env_break | output | 1 | Breakpoint recognised |
| illegal | output | 1 | Illegal SYSTEM word or CSR access |

## Verification
The hardest case to reach is a read-modify-write on a counter address that is legal only because its rs1 field is zero, while `rs1_val` carries all ones. A decoder that looked at the operand value instead of the field would either flag the access or corrupt the counter. The bench pairs each of these no-write forms with a nonzero `rs1_val`. It holds `tick_en` and `retire` at known counts so that a later read proves the counter kept its exact value. The exact cycle-counter values are not predictable from outside, so the bench checks the difference between two reads a known number of edges apart.

// File: rtl/csr_pkg.sv
// Package: shared encodings for the CSR access unit.
// Assumes a 32-bit instruction word with the standard field positions.
package csr_pkg;

    localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

    // Operation selected by the low two bits of funct3.
    typedef enum logic [1:0] {
        CSR_NONE  = 2'b00,
        CSR_WRITE = 2'b01,
        CSR_SET   = 2'b10,
        CSR_CLEAR = 2'b11
    } csr_op_e;

    // Base address of the low halves; the high halves sit 0x80 above.
    localparam logic [11:0] CNT_LO_BASE = 12'hC00;
    localparam logic [11:0] CNT_HI_BASE = 12'hC80;

endpackage

// File: rtl/csr_decode.sv
// Module: csr_decode
// Splits an instruction word into the CSR operation, its operand, the
// write-attempt flag and the environment-call/breakpoint flags.
// Assumes the immediate form takes its 5-bit value from the rs1 field.
module csr_decode
    import csr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            instr_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] rs1_val,
    output logic            is_csr,
    output csr_op_e         op,
    output logic [XLEN-1:0] operand,
    output logic            write_try,
    output logic [11:0]     csr_addr,
    output logic            rd_nz,
    output logic            ecall,
    output logic            ebreak,
    output logic            sys_bad
);

    logic [6:0] opc;
    logic [2:0] f3;
    logic [4:0] rs1_f;
    logic [4:0] rd_f;
    logic       sys;

    // Pull the fields out of the word.
    always_comb begin
        opc      = instr[6:0];
        rd_f     = instr[11:7];
        f3       = instr[14:12];
        rs1_f    = instr[19:15];
        csr_addr = instr[31:20];
        sys      = instr_valid && (opc == OPC_SYSTEM);
    end

    // Classify the operation and choose the operand source.
    always_comb begin
        op        = csr_op_e'(f3[1:0]);
        is_csr    = sys && (f3[1:0] != 2'b00);
        operand   = f3[2] ? {{(XLEN-5){1'b0}}, rs1_f} : rs1_val;
        write_try = is_csr && ((op == CSR_WRITE) || (rs1_f != 5'd0));
        rd_nz     = (rd_f != 5'd0);
        ecall     = sys && (f3 == 3'b000) && (rs1_f == 5'd0) && (rd_f == 5'd0)
                    && (csr_addr == 12'd0);
        ebreak    = sys && (f3 == 3'b000) && (rs1_f == 5'd0) && (rd_f == 5'd0)
                    && (csr_addr == 12'd1);
        sys_bad   = sys && !is_csr && !ecall && !ebreak;
    end

endmodule

// File: rtl/csr_counters.sv
// Module: csr_counters
// A bank of free-running counters, each advancing by one on its enable.
// Assumes the enable vector is already qualified by the caller.
module csr_counters #(
    parameter int NUM   = 3,
    parameter int CNT_W = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM-1:0]            inc,
    output logic [NUM-1:0][CNT_W-1:0] cnt
);

    for (genvar i = 0; i < NUM; i++) begin : g_cnt
        // Clear on reset, otherwise add one when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n)      cnt[i] <= '0;
            else if (inc[i]) cnt[i] <= cnt[i] + 1'b1;
        end

        AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n && inc[i] |=> cnt[i] == $past(cnt[i]) + 1'b1); // R2
        AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n && !inc[i] |=> $stable(cnt[i])); // R3
    end

endmodule

// File: rtl/csr_modify.sv
// Module: csr_modify
// Computes the new CSR value for write, set and clear.
// Assumes CSR_NONE leaves the value as it is.
module csr_modify
    import csr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  csr_op_e         op,
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] operand,
    output logic [XLEN-1:0] new_val
);

    // Apply the read-modify-write rule.
    always_comb begin
        unique case (op)
            CSR_WRITE: new_val = operand;
            CSR_SET:   new_val = old_val | operand;
            CSR_CLEAR: new_val = old_val & ~operand;
            default:   new_val = old_val;
        endcase
    end

endmodule

// File: rtl/csr_access_unit.sv
// Module: csr_access_unit (top)
// Executes CSR read/write/set/clear on a file of three 64-bit read-only
// counters (cycle, time, retired) plus one read/write scratch register,
// and flags environment calls, breakpoints and illegal accesses.
// Assumes the result is consumed combinationally in the issuing cycle.
module csr_access_unit
    import csr_pkg::*;
#(
    parameter int          XLEN         = 32,
    parameter logic [11:0] SCRATCH_ADDR = 12'h800
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] rs1_val,
    input  logic            retire,
    input  logic            tick_en,
    output logic [XLEN-1:0] rd_data,
    output logic            rd_we,
    output logic            env_call,
    output logic            env_break,
    output logic            illegal
);

    localparam int NUM_CNT = 3;
    localparam int CNT_W   = 2 * XLEN;

    logic                          is_csr;
    csr_op_e                       op;
    logic [XLEN-1:0]               operand;
    logic                          write_try;
    logic [11:0]                   addr;
    logic                          rd_nz;
    logic                          sys_bad;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
    logic [XLEN-1:0]               scratch_q;
    logic [XLEN-1:0]               scratch_d;
    logic [XLEN-1:0]               old_val;
    logic                          ro_hit;
    logic                          scr_hit;
    logic                          scr_we;

    csr_decode #(.XLEN(XLEN)) u_dec (
        .instr_valid (instr_valid),
        .instr       (instr),
        .rs1_val     (rs1_val),
        .is_csr      (is_csr),
        .op          (op),
        .operand     (operand),
        .write_try   (write_try),
        .csr_addr    (addr),
        .rd_nz       (rd_nz),
        .ecall       (env_call),
        .ebreak      (env_break),
        .sys_bad     (sys_bad)
    );

    // Index 0 cycle, 1 time, 2 retired.
    csr_counters #(.NUM(NUM_CNT), .CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   ({retire, tick_en, 1'b1}),
        .cnt   (cnt)
    );

    csr_modify #(.XLEN(XLEN)) u_mod (
        .op      (op),
        .old_val (scratch_q),
        .operand (operand),
        .new_val (scratch_d)
    );

    // Address decode and read multiplexer over the counter halves.
    always_comb begin
        ro_hit  = 1'b0;
        old_val = '0;
        scr_hit = (addr == SCRATCH_ADDR);
        for (int i = 0; i < NUM_CNT; i++) begin
            if (addr == CNT_LO_BASE + 12'(i)) begin
                ro_hit  = 1'b1;
                old_val = cnt[i][XLEN-1:0];
            end
            if (addr == CNT_HI_BASE + 12'(i)) begin
                ro_hit  = 1'b1;
                old_val = cnt[i][CNT_W-1:XLEN];
            end
        end
        if (scr_hit) old_val = scratch_q;
    end

    // Legality, writeback and scratch write enable.
    always_comb begin
        illegal = sys_bad || (is_csr && (!(ro_hit || scr_hit) || (ro_hit && write_try)));
        rd_we   = is_csr && !illegal && rd_nz;
        rd_data = is_csr ? old_val : '0;
        scr_we  = is_csr && !illegal && write_try && scr_hit;
    end

    // Scratch register storage.
    always_ff @(posedge clk) begin
        if (!rst_n)      scratch_q <= '0;
        else if (scr_we) scratch_q <= scratch_d;
    end

    AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({env_call, env_break, illegal})); // R11
    AST_ILLEGAL_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !rd_we); // R9
    AST_ILLEGAL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && illegal |=> $stable(scratch_q)); // R10
    AST_X0_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[11:7] == 5'd0) |-> !rd_we); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> !(env_call || env_break || illegal || rd_we)); // R13

endmodule

// File: tb/test_csr_access_unit.sv
module test_csr_access_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = 32'd0;
    logic [31:0] rs1_val = 32'd0;
    logic        retire = 1'b0;
    logic        tick_en = 1'b0;
    logic [31:0] rd_data;
    logic        rd_we, env_call, env_break, illegal;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] g_data;
    logic        g_we, g_ec, g_eb, g_ill;

    always #4 clk = ~clk;

    csr_access_unit i_csr_access_unit (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .rs1_val(rs1_val), .retire(retire), .tick_en(tick_en),
        .rd_data(rd_data), .rd_we(rd_we), .env_call(env_call),
        .env_break(env_break), .illegal(illegal)
    );

    function automatic logic [31:0] enc(input logic [11:0] a, input logic [4:0] r1,
                                        input logic [2:0] f3, input logic [4:0] rd);
        return {a, r1, f3, rd, 7'b1110011};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one word at a negedge, sample the outputs, then retire the slot.
    task automatic op(input logic [31:0] w, input logic [31:0] v, input logic vld = 1'b1);
        instr = w; rs1_val = v; instr_valid = vld;
        #2;
        g_data = rd_data; g_we = rd_we; g_ec = env_call; g_eb = env_break; g_ill = illegal;
        @(negedge clk);
        instr_valid = 1'b0; instr = 32'd0; rs1_val = 32'd0;
    endtask

    task automatic rd_csr(input logic [11:0] a);
        op(enc(a, 5'd0, 3'b010, 5'd1), 32'd0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rd_csr(12'hC00); chk("R1 cycle lo in reset", g_data, 32'd0);
        rd_csr(12'h800); chk("R1 scratch in reset", g_data, 32'd0);
        rst_n = 1'b1;
        rd_csr(12'hC01); chk("R1 time after reset", g_data, 32'd0);
        rd_csr(12'hC02); chk("R1 instret after reset", g_data, 32'd0);
    endtask

    task automatic t_cycle;
        logic [31:0] a, b;
        rd_csr(12'hC00); a = g_data;
        rd_csr(12'hC00); b = g_data;
        chk("R2 cycle step", b, a + 32'd1);
        repeat (5) @(negedge clk);
        rd_csr(12'hC00); chk("R2 cycle span", g_data, b + 32'd6);
        rd_csr(12'hC80); chk("R2 cycle hi", g_data, 32'd0);
    endtask

    task automatic t_time;
        tick_en = 1'b1; repeat (7) @(negedge clk); tick_en = 1'b0;
        rd_csr(12'hC01); chk("R3 time lo", g_data, 32'd7);
        rd_csr(12'hC81); chk("R3 time hi", g_data, 32'd0);
    endtask

    task automatic t_instret;
        retire = 1'b1; repeat (4) @(negedge clk); retire = 1'b0;
        rd_csr(12'hC02); chk("R4 instret lo", g_data, 32'd4);
        rd_csr(12'hC82); chk("R4 instret hi", g_data, 32'd0);
    endtask

    task automatic t_write;
        op(enc(12'h800, 5'd2, 3'b001, 5'd3), 32'hA5A5_0F0F);
        chk("R5 old value", g_data, 32'd0);
        chk("R5 rd_we", {31'd0, g_we}, 32'd1);
        rd_csr(12'h800); chk("R6 write reg", g_data, 32'hA5A5_0F0F);
        op(enc(12'h800, 5'h1F, 3'b101, 5'd3), 32'hFFFF_FFFF);
        chk("R5 old on writei", g_data, 32'hA5A5_0F0F);
        rd_csr(12'h800); chk("R6 writei zero-ext", g_data, 32'h0000_001F);
    endtask

    task automatic t_setclear;
        op(enc(12'h800, 5'd2, 3'b010, 5'd4), 32'hF000_0000);
        rd_csr(12'h800); chk("R7 set reg", g_data, 32'hF000_001F);
        op(enc(12'h800, 5'd2, 3'b011, 5'd4), 32'h0000_0003);
        rd_csr(12'h800); chk("R7 clear reg", g_data, 32'hF000_001C);
        op(enc(12'h800, 5'h0A, 3'b110, 5'd4), 32'd0);
        chk("R7 old on seti", g_data, 32'hF000_001C);
        rd_csr(12'h800); chk("R7 seti", g_data, 32'hF000_001E);
        op(enc(12'h800, 5'h1E, 3'b111, 5'd4), 32'd0);
        rd_csr(12'h800); chk("R7 cleari", g_data, 32'hF000_0000);
    endtask

    task automatic t_nowrite;
        op(enc(12'h800, 5'd0, 3'b011, 5'd1), 32'hFFFF_FFFF);
        rd_csr(12'h800); chk("R8 clear x0 keeps", g_data, 32'hF000_0000);
        op(enc(12'h800, 5'd0, 3'b010, 5'd1), 32'h0000_FFFF);
        rd_csr(12'h800); chk("R8 set x0 keeps", g_data, 32'hF000_0000);
        op(enc(12'hC01, 5'd0, 3'b110, 5'd1), 32'hFFFF_FFFF);
        chk("R8 seti0 on time legal", {31'd0, g_ill}, 32'd0);
        chk("R8 seti0 on time data", g_data, 32'd7);
        op(enc(12'hC02, 5'd0, 3'b011, 5'd1), 32'hFFFF_FFFF);
        chk("R8 clear x0 on instret legal", {31'd0, g_ill}, 32'd0);
        rd_csr(12'hC02); chk("R8 instret kept", g_data, 32'd4);
    endtask

    task automatic t_illegal;
        op(enc(12'hC02, 5'd2, 3'b001, 5'd1), 32'h1234_5678);
        chk("R9 write ro illegal", {31'd0, g_ill}, 32'd1);
        chk("R9 write ro no we", {31'd0, g_we}, 32'd0);
        rd_csr(12'hC02); chk("R9 instret unchanged", g_data, 32'd4);
        op(enc(12'hC81, 5'd1, 3'b110, 5'd1), 32'd0);
        chk("R9 seti ro illegal", {31'd0, g_ill}, 32'd1);
        rd_csr(12'hC81); chk("R9 time hi unchanged", g_data, 32'd0);
        op(enc(12'h123, 5'd0, 3'b010, 5'd1), 32'd0);
        chk("R10 unimpl illegal", {31'd0, g_ill}, 32'd1);
        chk("R10 unimpl no we", {31'd0, g_we}, 32'd0);
        op(enc(12'h801, 5'd2, 3'b001, 5'd1), 32'hDEAD_BEEF);
        rd_csr(12'h800); chk("R10 scratch untouched", g_data, 32'hF000_0000);
    endtask

    task automatic t_env;
        op(32'h0000_0073, 32'hFFFF_FFFF);
        chk("R11 ecall", {29'd0, g_ec, g_eb, g_ill}, 32'b100);
        chk("R11 ecall no we", {31'd0, g_we}, 32'd0);
        op(32'h0010_0073, 32'hFFFF_FFFF);
        chk("R11 ebreak", {29'd0, g_ec, g_eb, g_ill}, 32'b010);
        op(32'h0020_0073, 32'd0);
        chk("R11 bad f3 000", {29'd0, g_ec, g_eb, g_ill}, 32'b001);
        op(enc(12'h800, 5'd2, 3'b100, 5'd1), 32'h1);
        chk("R11 f3 100 illegal", {31'd0, g_ill}, 32'd1);
        rd_csr(12'h800); chk("R11 scratch untouched", g_data, 32'hF000_0000);
    endtask

    task automatic t_rdx0;
        op(enc(12'h800, 5'd5, 3'b001, 5'd0), 32'h0000_1234);
        chk("R12 rd x0 no we", {31'd0, g_we}, 32'd0);
        rd_csr(12'h800); chk("R12 side effect", g_data, 32'h0000_1234);
    endtask

    task automatic t_other;
        op({12'h800, 5'd2, 3'b001, 5'd1, 7'b0110011}, 32'hCAFE_0000);
        chk("R13 other opcode flags", {28'd0, g_we, g_ec, g_eb, g_ill}, 32'd0);
        op(enc(12'h800, 5'd2, 3'b001, 5'd1), 32'hCAFE_0001, 1'b0);
        chk("R13 invalid flags", {28'd0, g_we, g_ec, g_eb, g_ill}, 32'd0);
        rd_csr(12'h800); chk("R13 scratch kept", g_data, 32'h0000_1234);
    endtask

    initial begin
        @(negedge clk);
        t_reset;
        t_cycle;
        t_time;
        t_instret;
        t_write;
        t_setclear;
        t_nowrite;
        t_illegal;
        t_env;
        t_rdx0;
        t_other;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule